// File: doc/BRIEF.md
# Free-Running Timer With Latched Readout

A 12-bit counter that advances once per 1 µs timebase enable and is read through two byte-wide, read-only locations on a simple register bus. The bus is a single-cycle request interface: a read request with its address in one cycle returns the data, qualified by a valid strobe, in the next cycle.

Reading the low byte also copies the counter's upper four bits into a holding latch. A later read of the high-byte location returns that latch, not the live upper bits. Software that reads low first and then high therefore gets one consistent 12-bit value while the counter keeps running. The block also produces two periodic one-cycle pulses for an interrupt controller. One fires every 128 counts. The other fires every 1000 counts and is taken from its own modulo-1000 counter.

Top module: `free_timer_rd`

## Requirements
- R1: The counter rises by exactly one at each clock edge where `tick_i` is high. It holds its value at every other edge.
- R2: The counter wraps from 4095 (all ones) to 0 on the next tick.
- R3: A read (`req_i`=1, `we_i`=0) of address 8'h24 returns counter bits 7:0 as they stood in the request cycle. The data is on `rdata_o` with `rvalid_o`=1 in the following cycle.
- R4: A read of address 8'h24 loads counter bits 11:8, as they stood in the request cycle, into the holding latch. The latch changes at no other time.
- R5: A read of address 8'h25 returns the holding latch in `rdata_o` bits 3:0, with bits 7:4 zero. The live upper counter bits are not used.
- R6: After reset the counter and the holding latch are zero, and `rvalid_o`, `pulse_128_o` and `pulse_ms_o` are low.
- R7: `pulse_128_o` is high for exactly one cycle. That cycle follows each tick that takes counter bits 6:0 from 127 to 0.
- R8: `pulse_ms_o` is high for exactly one cycle. That cycle follows every 1000th tick since reset, counted by a separate modulo-1000 counter.
- R9: A write (`we_i`=1) to any address changes neither the counter nor the latch, and produces no `rvalid_o`.
- R10: A read of any other address returns 8'h00 with `rvalid_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 µs timebase enable, one cycle wide |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Bus write strobe (1 = write) |
| addr_i | input | 8 | Bus address |
| wdata_i | input | 8 | Bus write data (ignored) |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| pulse_128_o | output | 1 | Pulse every 128 counts |
| pulse_ms_o | output | 1 | Pulse every 1000 counts |

## Verification
The bench reads the low byte, runs several hundred ticks so that the upper bits move, and then reads the high byte. A design that returned the live bits would give the newer value, not the snapshot. Reads are placed right at the 4095-to-0 wrap and at every 128th and 1000th tick, which exposes counters that saturate, skip a value or pulse one cycle off. Writes of all-ones to both timer addresses, and ticks that are spaced apart, show whether writes disturb the count and whether the counter advances only on `tick_i`.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;
  localparam logic [7:0] ADDR_LO = 8'h24;
  localparam logic [7:0] ADDR_HI = 8'h25;
  typedef enum logic [1:0] {SEL_NONE, SEL_LO, SEL_HI} sel_e;
endpackage

// File: rtl/ftmr_count.sv
module ftmr_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == '1) |=> cnt_q == '0); // R2
endmodule

// File: rtl/ftmr_pulse.sv
module ftmr_pulse #(
  parameter int CNT_W    = 12,
  parameter int SUB_LOG2 = 7,
  parameter int MS_DIV   = 1000,
  localparam int MS_W    = $clog2(MS_DIV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             p_sub_o,
  output logic             p_ms_o
);
  logic [MS_W-1:0] ms_q;
  logic            ms_last;
  logic            sub_last;
  logic            p_sub_q, p_ms_q;

  assign ms_last  = (ms_q == MS_W'(MS_DIV - 1));
  assign sub_last = (cnt_i[SUB_LOG2-1:0] == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_q    <= '0;
      p_sub_q <= 1'b0;
      p_ms_q  <= 1'b0;
    end else begin
      p_sub_q <= tick_i && sub_last;
      p_ms_q  <= tick_i && ms_last;
      if (tick_i) ms_q <= ms_last ? '0 : ms_q + MS_W'(1);
    end
  end

  assign p_sub_o = p_sub_q;
  assign p_ms_o  = p_ms_q;

  AST_MS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q < MS_W'(MS_DIV)); // R8
  AST_MS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_ms_q |=> !p_ms_q); // R8
  AST_SUB_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_sub_q |=> !p_sub_q); // R7
  AST_SUB_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_sub_q |-> cnt_i[SUB_LOG2-1:0] == '0); // R7
endmodule

// File: rtl/ftmr_rdport.sv
module ftmr_rdport
  import ftmr_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int BUS_W   = 8,
  localparam int HI_W   = CNT_W - BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             rvalid_o
);
  sel_e             sel;
  logic             rd;
  logic [HI_W-1:0]  hold_q;
  logic [BUS_W-1:0] rdata_q;
  logic             rvalid_q;

  assign rd = req_i && !we_i;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == ADDR_LO)      sel = SEL_LO;
    else if (addr_i == ADDR_HI) sel = SEL_HI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) begin
        unique case (sel)
          SEL_LO: begin
            rdata_q <= cnt_i[BUS_W-1:0];
            hold_q  <= cnt_i[CNT_W-1:BUS_W];
          end
          SEL_HI:  rdata_q <= {{(BUS_W-HI_W){1'b0}}, hold_q};
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  AST_HOLD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_LO) |=> hold_q == $past(cnt_i[CNT_W-1:BUS_W])); // R4
  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd && sel == SEL_LO) |=> $stable(hold_q)); // R4
  AST_HI_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_HI) |=> rdata_q[BUS_W-1:HI_W] == '0); // R5
  AST_WR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> !rvalid_q); // R9
endmodule

// File: rtl/free_timer_rd.sv
module free_timer_rd #(
  parameter int CNT_W    = 12,
  parameter int SUB_LOG2 = 7,
  parameter int MS_DIV   = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       rvalid_o,
  output logic       pulse_128_o,
  output logic       pulse_ms_o
);
  localparam int BUS_W = 8;

  logic [CNT_W-1:0] cnt;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  ftmr_count #(.CNT_W(CNT_W)) i_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .cnt_o (cnt)
  );

  ftmr_pulse #(.CNT_W(CNT_W), .SUB_LOG2(SUB_LOG2), .MS_DIV(MS_DIV)) i_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_i  (cnt),
    .p_sub_o(pulse_128_o),
    .p_ms_o (pulse_ms_o)
  );

  ftmr_rdport #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_rdport (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .cnt_i   (cnt),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );
endmodule

// File: tb/test_free_timer_rd.sv
module test_free_timer_rd;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rvalid_o, pulse_128_o, pulse_ms_o;

  free_timer_rd i_free_timer_rd (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .pulse_128_o(pulse_128_o), .pulse_ms_o(pulse_ms_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int         checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         m_cnt = 0, m_hold = 0, m_ms = 0;
  logic       e128 = 1'b0, ems = 1'b0;
  bit         mon_on = 1'b0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected results pushed to the scoreboard
  task automatic cyc(bit tk, bit rq, bit w, logic [7:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    tick_i = tk; req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    if (rq && !w) begin
      tag_q.push_back(tag);
      if (a == 8'h24) begin
        exp_q.push_back(8'(m_cnt % 256));
        m_hold = m_cnt / 256;
      end else if (a == 8'h25) exp_q.push_back(8'(m_hold));
      else exp_q.push_back(8'h00);
    end
    e128 = tk && (m_cnt % 128 == 127);
    ems  = tk && (m_ms == 999);
    if (tk) begin
      m_ms  = (m_ms + 1) % 1000;
      m_cnt = (m_cnt + 1) % 4096;
    end
  endtask

  // monitor
  always @(posedge clk) begin
    if (mon_on) begin
      #2;
      if (rvalid_o) begin
        if (exp_q.size() == 0) chk("R9 unexpected rvalid", 1, 0);
        else begin
          string t;
          t = tag_q.pop_front();
          chk(t, rdata_o, exp_q.pop_front());
        end
      end
      chk("R7 pulse_128", pulse_128_o, e128);
      chk("R8 pulse_ms", pulse_ms_o, ems);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R6 rvalid after reset", rvalid_o, 0);
    chk("R6 rdata after reset", rdata_o, 0);
    chk("R6 pulse_128 after reset", pulse_128_o, 0);
    chk("R6 pulse_ms after reset", pulse_ms_o, 0);
    mon_on = 1'b1;
    cyc(0, 1, 0, 8'h25, 0, "R6 latch zero");
    cyc(0, 1, 0, 8'h24, 0, "R6 count zero");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, "");
    // writes ignored
    cyc(0, 1, 1, 8'h24, 8'hff, "");
    cyc(0, 1, 1, 8'h25, 8'hff, "");
    cyc(1, 1, 1, 8'h24, 8'hff, "");
    cyc(0, 1, 0, 8'h24, 0, "R9 count after write");
    cyc(0, 1, 0, 8'h25, 0, "R9 latch after write");
    // dense ticks with periodic reads
    for (int i = 0; i < 300; i++)
      cyc(1, (i % 37) == 0, 0, 8'h24, 0, "R3 low read dense");
    // sparse ticks
    for (int i = 0; i < 90; i++)
      cyc((i % 3) == 0, (i % 10) == 9, 0, 8'h24, 0, "R1 sparse ticks");
    // snapshot vs live
    cyc(0, 1, 0, 8'h24, 0, "R4 low read latch");
    for (int i = 0; i < 600; i++) cyc(1, 0, 0, 0, 0, "");
    cyc(1, 1, 0, 8'h25, 0, "R5 high returns snapshot");
    cyc(1, 1, 0, 8'h25, 0, "R5 high repeat");
    cyc(0, 1, 0, 8'h26, 0, "R10 other address");
    cyc(0, 1, 0, 8'h00, 0, "R10 address zero");
    // run through wrap
    for (int i = 0; i < 4300; i++) begin
      bit near;
      near = (m_cnt >= 4093) || (m_cnt <= 2);
      cyc(1, near, 0, 8'h24, 0, "R2 wrap low read");
    end
    cyc(0, 1, 0, 8'h25, 0, "R2 latch after wrap");
    repeat (4) cyc(0, 0, 0, 0, 0, "");
    mon_on = 1'b0;
    chk("R3 all reads returned", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule